// File: doc/BRIEF.md
# Iterative unsigned shift-add multiplier

This block multiplies two unsigned 32-bit operands and returns the full 64-bit product as separate upper and lower 32-bit words. It computes one multiplier bit per clock. A single double-width register holds both the growing partial product and the not-yet-consumed multiplier bits. A 32-bit adder works only on the upper half of that register.

A one-cycle `start` pulse, given while the block is idle, captures `a_in` as the multiplicand and `b_in` as the multiplier. The block then raises `busy`. It performs one conditional-add-and-shift per clock until every multiplier bit has been used. It then drops `busy` and pulses `done` for one cycle. The product stays on `hi` and `lo` until the next accepted `start`. A `start` that arrives while the block is busy is ignored.

Top module: `shiftadd_mul`

## Requirements
- R1: After a clock edge with `rst_n` low, `busy` and `done` are 0, and `hi` and `lo` are 0.
- R2: A `start` sampled high while `busy` is 0 is accepted on that edge, and `busy` reads 1 after it.
- R3: After an accepted `start`, `busy` stays 1 and `done` stays 0 for the next OP_W-1 edges. After the OP_W-th edge, `busy` is 0 and `done` is 1.
- R4: When `done` is 1, `{hi, lo}` equals the unsigned product of the accepted `a_in` and `b_in`, with `hi` as the upper OP_W bits.
- R5: No carry out of the upper-half addition is lost: all-ones operands give the correct full-width product.
- R6: A `start` sampled while `busy` is 1 is ignored. The running operation's timing and result are unchanged.
- R7: `done` is high for exactly one cycle per operation, and never together with `busy`.
- R8: While the block is idle and no `start` is accepted, `hi` and `lo` hold their last values.
- R9: The captured multiplicand does not change while an operation runs.
- R10: A zero operand on either input yields a zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a multiply, sampled when idle |
| a_in | input | OP_W | Multiplicand operand |
| b_in | input | OP_W | Multiplier operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| hi | output | OP_W | Upper half of the product |
| lo | output | OP_W | Lower half of the product |

## Verification
The bench uses a 6-bit build and sweeps every operand pair. This covers zero operands, powers of two, and all-ones pairs, whose upper-half sums carry out on nearly every step; the all-ones pairs expose a dropped carry bit. For every pair, `busy` and `done` are checked cycle by cycle, which separates an off-by-one iteration count from a wrong result. Directed runs then raise `start` again in the middle of an operation, with different operands, and check that neither the timing nor the product changes. The bench also checks that the product holds through idle cycles after `done`.

// File: rtl/shiftadd_mul_pkg.sv
// Package: shared types for the shift-add multiplier.
// Assumes: nothing beyond standard SystemVerilog.
package shiftadd_mul_pkg;
    typedef enum logic [0:0] {
        MUL_IDLE = 1'b0,
        MUL_RUN  = 1'b1
    } mul_state_e;
endpackage

// File: rtl/sam_ctrl.sv
// Module: sequencing control for the shift-add multiplier.
// Accepts start only when idle, counts OP_W iterations, then pulses done.
// Assumes: synchronous active-low reset; start may be held or pulsed.
module sam_ctrl
    import shiftadd_mul_pkg::*;
#(
    parameter int OP_W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(OP_W + 1);
    localparam logic [CNT_W-1:0] LAST_IT = CNT_W'(OP_W - 1);

    mul_state_e       state_q;
    logic [CNT_W-1:0] iter_q;

    // Decode the datapath strobes from the current state.
    always_comb begin
        load = (state_q == MUL_IDLE) && start;
        step = (state_q == MUL_RUN);
    end

    // State, iteration count and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MUL_IDLE;
            iter_q  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                MUL_IDLE: begin
                    if (start) begin
                        state_q <= MUL_RUN;
                        iter_q  <= '0;
                    end
                end
                MUL_RUN: begin
                    if (iter_q == LAST_IT) begin
                        state_q <= MUL_IDLE;
                        iter_q  <= '0;
                        done    <= 1'b1;
                    end else begin
                        iter_q <= iter_q + 1'b1;
                    end
                end
                default: state_q <= MUL_IDLE;
            endcase
        end
    end

    assign busy = (state_q == MUL_RUN);

    // R7: done lasts one cycle and never overlaps busy.
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));
    // R6: a running operation is not restarted or cut short by start.
    assert_run_continues_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && iter_q != LAST_IT) |=> busy);
    // R3: the iteration counter never passes the operand width.
    assert_iter_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        iter_q <= LAST_IT);
endmodule

// File: rtl/sam_datapath.sv
// Module: datapath of the shift-add multiplier.
// Holds the multiplicand and a 2*OP_W product register whose low half
// starts as the multiplier. Each step adds the multiplicand to the
// upper half when bit 0 is set, then shifts everything right by one,
// keeping the adder carry as the new top bit.
// Assumes: load and step are never both high.
module sam_datapath #(
    parameter int OP_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic [OP_W-1:0] a_in,
    input  logic [OP_W-1:0] b_in,
    output logic [OP_W-1:0] hi,
    output logic [OP_W-1:0] lo
);
    localparam int PROD_W = 2 * OP_W;

    logic [OP_W-1:0]   mcand_q;
    logic [PROD_W-1:0] prod_q;
    logic [OP_W:0]     upper_sum;

    // Conditional add of the multiplicand into the upper half, with carry.
    always_comb begin
        upper_sum = {1'b0, prod_q[PROD_W-1:OP_W]}
                  + (prod_q[0] ? {1'b0, mcand_q} : {(OP_W+1){1'b0}});
    end

    // Operand capture and one add-and-shift per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (load) begin
            mcand_q <= a_in;
            prod_q  <= {{OP_W{1'b0}}, b_in};
        end else if (step) begin
            prod_q  <= {upper_sum, prod_q[OP_W-1:1]};
        end
    end

    assign hi = prod_q[PROD_W-1:OP_W];
    assign lo = prod_q[OP_W-1:0];

    // R9: the multiplicand is held while stepping.
    assert_mcand_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> $stable(mcand_q));
    // R8: without load or step, the product register holds.
    assert_prod_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> ($stable(hi) && $stable(lo)));
    // R2: a load places the multiplier in the low half and clears the top.
    assert_load_image_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (hi == '0 && lo == $past(b_in)));
    // Strobes from the controller are exclusive.
    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && step));
endmodule

// File: rtl/shiftadd_mul.sv
// Module: top of the iterative unsigned shift-add multiplier.
// Computes the 2*OP_W-bit product of a_in and b_in over OP_W cycles.
// Assumes: synchronous active-low reset; operands sampled on the
// accepting edge only.
module shiftadd_mul #(
    parameter int OP_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [OP_W-1:0] a_in,
    input  logic [OP_W-1:0] b_in,
    output logic            busy,
    output logic            done,
    output logic [OP_W-1:0] hi,
    output logic [OP_W-1:0] lo
);
    logic load_s;
    logic step_s;

    sam_ctrl #(.OP_W(OP_W)) ctrl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load_s),
        .step  (step_s),
        .busy  (busy),
        .done  (done)
    );

    sam_datapath #(.OP_W(OP_W)) dp_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_s),
        .step  (step_s),
        .a_in  (a_in),
        .b_in  (b_in),
        .hi    (hi),
        .lo    (lo)
    );

    // R2: an idle start makes busy rise on the next cycle.
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

// File: tb/shiftadd_mul_tb_top.sv
// Bench: exhaustive sweep of a small-width multiplier plus directed cases.
module shiftadd_mul_tb_top;
    localparam int W = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         busy, done;
    logic [W-1:0] hi, lo;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    shiftadd_mul #(.OP_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
        .busy(busy), .done(done), .hi(hi), .lo(lo)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Runs one multiply; if poke is set, a different start arrives mid-run.
    task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                           input bit poke);
        logic [2*W-1:0] exp;
        exp = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        start = 1'b1; a_in = a; b_in = b;
        @(negedge clk);
        start = 1'b0; a_in = ~a; b_in = ~b;
        check("R2 busy after start", 64'(busy), 64'd1);
        for (int k = 1; k < W; k++) begin
            if (poke && k == 2) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R3 busy during run", 64'(busy), 64'd1);
            check("R3 no early done", 64'(done), 64'd0);
        end
        @(negedge clk);
        check("R3 done after OP_W steps", 64'(done), 64'd1);
        check("R7 busy low with done", 64'(busy), 64'd0);
        if (poke) check("R6 product unaffected", 64'({hi, lo}), 64'(exp));
        else if (a == '1 && b == '1) check("R5 carry kept", 64'({hi, lo}), 64'(exp));
        else if (a == '0 || b == '0) check("R10 zero product", 64'({hi, lo}), 64'd0);
        else check("R4 product", 64'({hi, lo}), 64'(exp));
        @(negedge clk);
        check("R7 done single cycle", 64'(done), 64'd0);
        check("R8 hold after done", 64'({hi, lo}), 64'(exp));
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=%0d expected=<190000", cycles);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 busy reset", 64'(busy), 64'd0);
        check("R1 done reset", 64'(done), 64'd0);
        check("R1 product reset", 64'({hi, lo}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < (1 << W); a++)
            for (int b = 0; b < (1 << W); b++)
                run_mul(W'(a), W'(b), 1'b0);
        run_mul('1, '1, 1'b1);
        run_mul(W'(37), W'(19), 1'b1);
        repeat (5) @(negedge clk);
        check("R8 idle hold", 64'({hi, lo}), 64'(37 * 19));
        check("R8 idle not busy", 64'(busy), 64'd0);
        finish_run();
    end
endmodule